// File: doc/BRIEF.md
# Snooze Power-Down Sequencer

This block controls when a synchronous memory enters and leaves its low-power snooze state. An asynchronous, active-high snooze request first passes through a synchroniser. After a fixed number of cycles, the request closes the memory's command inputs and forces its data pins to high impedance. The memory then stays in snooze for as long as the request stays high. The array is only deselected during snooze, so its contents are kept.

When the request drops, an exit window of a fixed number of cycles follows. In this window the memory may take deselect and read cycles only. A write offered in the window is not performed, and a one-cycle flag reports that it was refused. During the entry count, commands still reach the core. Commands issued there are not guaranteed to finish once snooze takes hold, so the user should let them drain first.

Top module: `snz_seq`

## Requirements
- R1: A rising snooze request is seen by the sequencer after the synchroniser's stages. The status output rises in the third cycle after the request is first sampled high (default two-flop synchroniser).
- R2: After the status output rises, commands still pass for ENTRY_CYC cycles (default 2). Then the input block and the high-impedance force both assert.
- R3: While snooze is in effect, the read and write strobes and the reject flag stay low whatever the command inputs do, and the high-impedance force is high.
- R4: Snooze lasts for as long as the synchronised request stays high.
- R5: When the synchronised request falls, the sequencer holds an exit window of EXIT_CYC cycles (default 2). In the window the status output stays high and the high-impedance force is low. Normal operation follows the window.
- R6: A write request (valid=1, write=1) during the exit window produces no write strobe. It raises the reject flag for exactly the cycles in which it is offered.
- R7: A read request (valid=1, write=0) during the exit window produces a read strobe. A deselect (valid=0) produces no strobe and no reject.
- R8: In normal operation, a read request drives the read strobe and a write request drives the write strobe. The status output is low.
- R9: An active-low reset, applied asynchronously, returns the sequencer to normal operation with the status, force and block outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snooze_req | input | 1 | Asynchronous active-high snooze request |
| cmd_valid | input | 1 | A memory cycle is requested (0 = deselect) |
| cmd_write | input | 1 | 1 = write cycle, 0 = read cycle |
| core_rd | output | 1 | Read cycle forwarded to the array |
| core_wr | output | 1 | Write cycle forwarded to the array |
| wr_reject | output | 1 | Write refused during the exit window |
| dq_hiz | output | 1 | Force the data pins to high impedance |
| in_block | output | 1 | Command inputs are ignored |
| snoozing | output | 1 | Sequencer is between entry and the end of the exit count |

## Verification
The bench builds the block with its defaults: two synchroniser stages, and entry and exit counts of two cycles each. Snooze therefore takes effect on the fifth edge after the request is applied, and normal operation resumes on the fifth edge after the request is removed. These short, known latencies let one cycle-by-cycle table cover every part of the sequence. The table covers a write and a read slipping through the entry count, commands being ignored during snooze, a refused write in the exit window, and a read accepted in it. Directed cases then cover a deselect-only exit window and a reset applied while the block is in snooze.

// File: rtl/snz_pkg.sv
package snz_pkg;
  typedef enum logic [1:0] {
    SNZ_RUN   = 2'd0,
    SNZ_ENTER = 2'd1,
    SNZ_SLEEP = 2'd2,
    SNZ_EXIT  = 2'd3
  } snz_state_e;
endpackage

// File: rtl/snz_sync.sv
module snz_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = async_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/snz_fsm.sv
module snz_fsm
  import snz_pkg::*;
#(
  parameter int unsigned ENTRY_CYC = 2,
  parameter int unsigned EXIT_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_s,
  output snz_state_e state_o
);
  localparam int unsigned MAXC = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int unsigned CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_CYC - 1);
  localparam logic [CW-1:0] EXIT_LAST  = CW'(EXIT_CYC - 1);

  snz_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = '0;
    cnt_en = 1'b0;
    unique case (st_q)
      SNZ_RUN: begin
        if (req_s) begin
          st_d = SNZ_ENTER;
          cnt_en = 1'b1;
        end
      end
      SNZ_ENTER: begin
        cnt_en = 1'b1;
        if (cnt_q == ENTRY_LAST) st_d = SNZ_SLEEP;
        else                     cnt_d = cnt_q + 1'b1;
      end
      SNZ_SLEEP: begin
        if (!req_s) begin
          st_d = SNZ_EXIT;
          cnt_en = 1'b1;
        end
      end
      SNZ_EXIT: begin
        cnt_en = 1'b1;
        if (req_s)                   st_d = SNZ_ENTER;
        else if (cnt_q == EXIT_LAST) st_d = SNZ_RUN;
        else                         cnt_d = cnt_q + 1'b1;
      end
      default: st_d = SNZ_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SNZ_RUN;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;

  // R2
  sleep_from_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SNZ_SLEEP) ##1 (st_q == SNZ_SLEEP) |-> $past(st_q) == SNZ_ENTER);
  // R4
  sleep_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SNZ_SLEEP && req_s) |=> (st_q == SNZ_SLEEP));
  // R5
  exit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SNZ_EXIT && !req_s && cnt_q == EXIT_LAST) |=> (st_q == SNZ_RUN));
endmodule

// File: rtl/snz_gate.sv
module snz_gate
  import snz_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  snz_state_e state_i,
  input  logic       cmd_valid,
  input  logic       cmd_write,
  output logic       core_rd,
  output logic       core_wr,
  output logic       wr_reject,
  output logic       dq_hiz,
  output logic       in_block,
  output logic       snoozing
);
  logic asleep, in_exit;

  always_comb begin
    asleep    = (state_i == SNZ_SLEEP);
    in_exit   = (state_i == SNZ_EXIT);
    in_block  = asleep;
    dq_hiz    = asleep;
    snoozing  = (state_i != SNZ_RUN);
    core_rd   = cmd_valid && !cmd_write && !asleep;
    core_wr   = cmd_valid && cmd_write && !asleep && !in_exit;
    wr_reject = cmd_valid && cmd_write && in_exit;
  end

  // R3
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_hiz |-> !(core_rd || core_wr || wr_reject));
  // R6
  reject_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> !core_wr && snoozing && !dq_hiz);
  // R8
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_rd, core_wr, wr_reject}));
endmodule

// File: rtl/snz_seq.sv
module snz_seq
  import snz_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ENTRY_CYC   = 2,
  parameter int unsigned EXIT_CYC    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic snooze_req,
  input  logic cmd_valid,
  input  logic cmd_write,
  output logic core_rd,
  output logic core_wr,
  output logic wr_reject,
  output logic dq_hiz,
  output logic in_block,
  output logic snoozing
);
  logic       req_s;
  snz_state_e state;

  snz_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(snooze_req), .sync_o(req_s)
  );

  snz_fsm #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .state_o(state)
  );

  snz_gate u_gate (
    .clk(clk), .rst_n(rst_n), .state_i(state),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .core_rd(core_rd), .core_wr(core_wr), .wr_reject(wr_reject),
    .dq_hiz(dq_hiz), .in_block(in_block), .snoozing(snoozing)
  );

  // R1
  status_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snoozing) |-> $past(req_s));
endmodule

// File: tb/snz_seq_bench.sv
module snz_seq_bench;
  logic clk = 1'b0;
  logic rst_n, snooze_req, cmd_valid, cmd_write;
  logic core_rd, core_wr, wr_reject, dq_hiz, in_block, snoozing;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  snz_seq u_snz_seq (
    .clk(clk), .rst_n(rst_n), .snooze_req(snooze_req),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .core_rd(core_rd), .core_wr(core_wr), .wr_reject(wr_reject),
    .dq_hiz(dq_hiz), .in_block(in_block), .snoozing(snoozing)
  );

  // bits: [7]req [6]valid [5]write | expected [4]rd [3]wr [2]reject [1]hiz/block [0]status
  localparam int NV = 14;
  localparam logic [7:0] VEC [NV] = '{
    8'b0_11_01000, // R8 write in run
    8'b1_10_10000, // R8 read in run, request rises
    8'b1_11_01000, // R1 still run during sync
    8'b1_00_00000, // R1 still run
    8'b1_11_01001, // R2 status up, write still passes
    8'b1_10_10001, // R2 read still passes
    8'b1_11_00011, // R3 snooze, write ignored
    8'b0_10_00011, // R4 request drops, still asleep
    8'b0_11_00011, // R4
    8'b0_11_00011, // R4
    8'b0_11_00101, // R6 exit window, write refused
    8'b0_10_10001, // R7 read in exit window
    8'b0_11_01000, // R5 back to run
    8'b0_00_00000  // R8 deselect
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; snooze_req = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0;
    #1;
    // R9 reset state
    chk("R9 status", snoozing, 1'b0);
    chk("R9 hiz", dq_hiz, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      snooze_req = VEC[i][7]; cmd_valid = VEC[i][6]; cmd_write = VEC[i][5];
      #1;
      chk($sformatf("R8/R7 rd v%0d", i), core_rd, VEC[i][4]);
      chk($sformatf("R8/R6 wr v%0d", i), core_wr, VEC[i][3]);
      chk($sformatf("R6 reject v%0d", i), wr_reject, VEC[i][2]);
      chk($sformatf("R3 hiz v%0d", i), dq_hiz, VEC[i][1]);
      chk($sformatf("R2 block v%0d", i), in_block, VEC[i][1]);
      chk($sformatf("R1/R5 status v%0d", i), snoozing, VEC[i][0]);
    end

    // R7 deselect-only exit window: enter again, then leave with valid=0
    @(negedge clk); snooze_req = 1'b1; cmd_valid = 1'b0;
    repeat (5) @(negedge clk);
    #1 chk("R3 asleep again", dq_hiz, 1'b1);
    snooze_req = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R5 exit status", snoozing, 1'b1);
    chk("R5 exit hiz", dq_hiz, 1'b0);
    chk("R7 deselect no reject", wr_reject, 1'b0);
    chk("R7 deselect no read", core_rd, 1'b0);
    repeat (2) @(negedge clk);
    #1 chk("R5 run after exit", snoozing, 1'b0);

    // R4 long snooze, then R9 asynchronous reset in snooze
    snooze_req = 1'b1;
    repeat (20) @(negedge clk);
    #1 chk("R4 long snooze hiz", dq_hiz, 1'b1);
    #2 rst_n = 1'b0;
    #1;
    chk("R9 async status", snoozing, 1'b0);
    chk("R9 async hiz", dq_hiz, 1'b0);
    chk("R9 async block", in_block, 1'b0);
    snooze_req = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cmd_valid = 1'b1; cmd_write = 1'b1;
    #1 chk("R8 write after reset", core_wr, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule